// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional

This block sits between one processor's load/store port and its memory port. It forwards ordinary loads and stores unchanged. It also supports a linked pair of accesses for building atomic read-modify-write sequences without a dedicated swap operation.

A load-linked access reads memory like any load and remembers the word address as a reservation. A store-conditional access writes memory only while that reservation is still live and names the same address. It answers with a one-bit status instead of silently completing.

Several snoop ports report writes made by other agents. A remote write that hits the reserved address kills the reservation, so a later store-conditional fails. Software then retries its sequence. Every request gets exactly one response in the following cycle. Read data arrives from a memory that returns it one cycle after the request.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked request (op code 2'b10) issues a memory read to its address and records that address as the reservation with the valid flag set. Its response, one cycle later, carries the memory read data.
- R2: A store-conditional request (op code 2'b11) writes its data to memory only when the reservation is valid and its address equals the reserved address.
- R3: The response to a store-conditional carries bit 0 = 1 on success and 0 on failure, with all other bits zero. A plain store (op code 2'b01) responds with all zeros, and a plain load (op code 2'b00) responds with the memory read data.
- R4: A failing store-conditional raises no memory request, so memory is left unchanged.
- R5: Every store-conditional, whether it succeeds or fails, invalidates the reservation.
- R6: A valid write on any snoop port whose address equals the reserved address invalidates the reservation. Snoop writes to other addresses leave it intact.
- R7: When a snoop write to the reserved address arrives in the same cycle as a store-conditional to that address, the store-conditional fails.
- R8: A new load-linked replaces any existing reservation. If a snoop write to the new address arrives in that same cycle, the reservation is left invalid.
- R9: The processor's own plain loads and stores do not change the reservation.
- R10: After reset the reservation is invalid and no response or memory request is produced.
- R11: Each accepted request produces exactly one response in the cycle after it, and no response appears in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request present |
| req_op_i | input | 2 | 00 load, 01 store, 10 load-linked, 11 store-conditional |
| req_addr_i | input | ADDR_W | Word address of the request |
| req_wdata_i | input | DATA_W | Store data |
| snoop_valid_i | input | NUM_SNOOP | Remote write seen, one bit per snoop port |
| snoop_addr_i | input | NUM_SNOOP*ADDR_W | Remote write addresses, port k in slice k |
| mem_req_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, one cycle after a read |
| rsp_valid_o | output | 1 | Response present |
| rsp_data_o | output | DATA_W | Load data or store-conditional status |

## Verification
The hardest situation to reach is the collision of a snoop write with a store-conditional or a load-linked in the same cycle. These are the only cases where a priority decides the outcome. The bench drives both the request and a snoop on a chosen port in one call, so the snoop can land in the exact cycle of the store-conditional or the load-linked. Each collision is paired with a near-miss, where the snoop is one word off, to show that only a true address match decides. The final state is then read back with a plain load, and the memory-request line is observed in the request cycle.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LL    = 2'b10,
    OP_SC    = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_snoop_match.sv
module llsc_snoop_match #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned NUM_SNOOP = 2
) (
  input  logic [NUM_SNOOP-1:0]        snoop_valid_i,
  input  logic [NUM_SNOOP*ADDR_W-1:0] snoop_addr_i,
  input  logic [ADDR_W-1:0]           cmp_addr_i,
  output logic                        hit_o
);
  logic [NUM_SNOOP-1:0] port_hit;

  for (genvar k = 0; k < NUM_SNOOP; k++) begin : g_port
    assign port_hit[k] = snoop_valid_i[k] &&
                         (snoop_addr_i[k*ADDR_W +: ADDR_W] == cmp_addr_i);
  end

  assign hit_o = |port_hit;
endmodule

// File: rtl/llsc_link_reg.sv
module llsc_link_reg #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              set_kill_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else if (set_i) begin
      addr_o  <= set_addr_i;
      valid_o <= !set_kill_i;  // remote write racing the new link
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/llsc_rsp_stage.sv
module llsc_rsp_stage
  import llsc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  llsc_op_e          op_i,
  input  logic              sc_ok_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  llsc_op_e op_q;
  logic     ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      op_q        <= OP_LOAD;
      ok_q        <= 1'b0;
    end else begin
      rsp_valid_o <= fire_i;
      if (fire_i) begin
        op_q <= op_i;
        ok_q <= sc_ok_i;
      end
    end
  end

  always_comb begin
    unique case (op_q)
      OP_LOAD, OP_LL: rsp_data_o = mem_rdata_i;
      OP_SC:          rsp_data_o = {{(DATA_W-1){1'b0}}, ok_q};
      default:        rsp_data_o = '0;
    endcase
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_SNOOP = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  input  logic [1:0]                  req_op_i,
  input  logic [ADDR_W-1:0]           req_addr_i,
  input  logic [DATA_W-1:0]           req_wdata_i,
  input  logic [NUM_SNOOP-1:0]        snoop_valid_i,
  input  logic [NUM_SNOOP*ADDR_W-1:0] snoop_addr_i,
  output logic                        mem_req_o,
  output logic                        mem_we_o,
  output logic [ADDR_W-1:0]           mem_addr_o,
  output logic [DATA_W-1:0]           mem_wdata_o,
  input  logic [DATA_W-1:0]           mem_rdata_i,
  output logic                        rsp_valid_o,
  output logic [DATA_W-1:0]           rsp_data_o
);
  llsc_op_e          op;
  logic              is_ll, is_sc, is_wr;
  logic              link_vld;
  logic [ADDR_W-1:0] link_addr;
  logic              snoop_hits_link, snoop_hits_req;
  logic              sc_ok;

  assign op    = llsc_op_e'(req_op_i);
  assign is_ll = req_valid_i && (op == OP_LL);
  assign is_sc = req_valid_i && (op == OP_SC);
  assign is_wr = (op == OP_STORE) || (op == OP_SC);

  llsc_snoop_match #(.ADDR_W(ADDR_W), .NUM_SNOOP(NUM_SNOOP)) u_match_link (
    .snoop_valid_i (snoop_valid_i),
    .snoop_addr_i  (snoop_addr_i),
    .cmp_addr_i    (link_addr),
    .hit_o         (snoop_hits_link)
  );

  llsc_snoop_match #(.ADDR_W(ADDR_W), .NUM_SNOOP(NUM_SNOOP)) u_match_req (
    .snoop_valid_i (snoop_valid_i),
    .snoop_addr_i  (snoop_addr_i),
    .cmp_addr_i    (req_addr_i),
    .hit_o         (snoop_hits_req)
  );

  // snoop beats a same-cycle store-conditional
  assign sc_ok = is_sc && link_vld && (req_addr_i == link_addr) && !snoop_hits_link;

  llsc_link_reg #(.ADDR_W(ADDR_W)) u_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (is_ll),
    .set_addr_i (req_addr_i),
    .set_kill_i (snoop_hits_req),
    .clr_i      (is_sc || snoop_hits_link),
    .valid_o    (link_vld),
    .addr_o     (link_addr)
  );

  assign mem_req_o   = req_valid_i && (!is_sc || sc_ok);
  assign mem_we_o    = mem_req_o && is_wr;
  assign mem_addr_o  = req_addr_i;
  assign mem_wdata_o = req_wdata_i;

  llsc_rsp_stage #(.DATA_W(DATA_W)) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (req_valid_i),
    .op_i        (op),
    .sc_ok_i     (sc_ok),
    .mem_rdata_i (mem_rdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o)
  );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_SNOOP = 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        req_valid_i,
  input logic [1:0]                  req_op_i,
  input logic [ADDR_W-1:0]           req_addr_i,
  input logic [NUM_SNOOP-1:0]        snoop_valid_i,
  input logic [NUM_SNOOP*ADDR_W-1:0] snoop_addr_i,
  input logic                        mem_req_o,
  input logic                        mem_we_o,
  input logic                        rsp_valid_o,
  input logic [DATA_W-1:0]           rsp_data_o,
  input logic                        link_vld,
  input logic [ADDR_W-1:0]           link_addr
);
  logic hit_link, hit_req;
  logic is_ll, is_sc;

  always_comb begin
    hit_link = 1'b0;
    hit_req  = 1'b0;
    for (int k = 0; k < int'(NUM_SNOOP); k++) begin
      if (snoop_valid_i[k] && snoop_addr_i[k*ADDR_W +: ADDR_W] == link_addr) hit_link = 1'b1;
      if (snoop_valid_i[k] && snoop_addr_i[k*ADDR_W +: ADDR_W] == req_addr_i) hit_req = 1'b1;
    end
  end

  assign is_ll = req_valid_i && (req_op_i == 2'b10);
  assign is_sc = req_valid_i && (req_op_i == 2'b11);

  p_rsp_after_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_no_stray_rsp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_ll_links_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ll && !hit_req) |=> (link_vld && link_addr == $past(req_addr_i)));
  p_ll_kill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ll && hit_req) |=> !link_vld);
  p_sc_write_cond_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sc && mem_req_o) |-> (mem_we_o && link_vld && req_addr_i == link_addr));
  p_sc_fail_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sc && !link_vld) |-> !mem_req_o);
  p_sc_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sc |=> !link_vld);
  p_snoop_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_ll && hit_link) |=> !link_vld);
  p_snoop_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sc && hit_link) |-> !mem_req_o);
  p_sc_status_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sc |=> (rsp_data_o[DATA_W-1:1] == '0));
endmodule

bind llsc_monitor llsc_monitor_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SNOOP(NUM_SNOOP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
  .req_addr_i(req_addr_i), .snoop_valid_i(snoop_valid_i), .snoop_addr_i(snoop_addr_i),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .rsp_valid_o(rsp_valid_o),
  .rsp_data_o(rsp_data_o), .link_vld(link_vld), .link_addr(link_addr)
);

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [NS-1:0] snoop_valid = '0;
  logic [NS*AW-1:0] snoop_addr = '0;
  logic mem_req, mem_we, rsp_valid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, rsp_data;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] mem [0:255];

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #5 clk = ~clk;

  llsc_monitor #(.ADDR_W(AW), .DATA_W(DW), .NUM_SNOOP(NS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .snoop_valid_i(snoop_valid),
    .snoop_addr_i(snoop_addr), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data)
  );

  // memory model: read data one cycle later
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  // monitor: pop expected responses
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected response act=%h exp=none", rsp_data);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rsp_data !== e) begin
          errors++;
          $display("FAIL %s rsp act=%h exp=%h", t, rsp_data, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      finish_run();
    end
  end

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] addr,
                       input logic [DW-1:0] wd, input logic [NS-1:0] sv,
                       input logic [AW-1:0] sa0, input logic [AW-1:0] sa1,
                       input logic exp_req, input logic [DW-1:0] exp_rsp,
                       input string tag);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
    snoop_valid = sv; snoop_addr = {sa1, sa0};
    #1;
    checks++;
    if (mem_req !== exp_req) begin
      errors++;
      $display("FAIL %s mem_req act=%b exp=%b", tag, mem_req, exp_req);
    end
    exp_q.push_back(exp_rsp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0; snoop_valid = '0;
  endtask

  task automatic ld(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
    issue(2'b00, a, '0, '0, '0, '0, 1'b1, e, t);
  endtask
  task automatic st(input logic [AW-1:0] a, input logic [DW-1:0] d, input string t);
    issue(2'b01, a, d, '0, '0, '0, 1'b1, '0, t);
  endtask
  task automatic ll(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
    issue(2'b10, a, '0, '0, '0, '0, 1'b1, e, t);
  endtask
  task automatic sc(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic ok, input string t);
    issue(2'b11, a, d, '0, '0, '0, ok, {31'b0, ok}, t);
  endtask
  task automatic snoop_only(input logic [NS-1:0] sv, input logic [AW-1:0] sa0, input logic [AW-1:0] sa1);
    snoop_valid = sv; snoop_addr = {sa1, sa0};
    @(negedge clk);
    snoop_valid = '0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    @(negedge clk); @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || mem_req !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset rsp/mem act=%b%b exp=00", rsp_valid, mem_req);
    end
    rst_n = 1'b1;
    @(negedge clk);
    sc(16'h0010, 32'd1, 1'b0, "R10 sc after reset");
    ld(16'h0010, 32'd0, "R10 untouched");

    st(16'h0010, 32'd5, "R3 store rsp zero");
    ld(16'h0010, 32'd5, "R3 load data");
    ll(16'h0010, 32'd5, "R1 ll data");
    sc(16'h0010, 32'd6, 1'b1, "R2 sc ok");
    ld(16'h0010, 32'd6, "R2 written");
    sc(16'h0010, 32'd7, 1'b0, "R5 second sc");
    ld(16'h0010, 32'd6, "R4 no write");

    ll(16'h0020, 32'd0, "R1 ll");
    sc(16'h0024, 32'd8, 1'b0, "R2 addr mismatch");
    ld(16'h0024, 32'd0, "R4 mismatch no write");
    sc(16'h0020, 32'd8, 1'b0, "R5 cleared by failed sc");

    ll(16'h0030, 32'd0, "R1 ll");
    snoop_only(2'b01, 16'h0030, 16'h0000);
    sc(16'h0030, 32'd9, 1'b0, "R6 snoop kill port0");
    ld(16'h0030, 32'd0, "R6 no write");
    ll(16'h0030, 32'd0, "R1 ll");
    snoop_only(2'b10, 16'h0000, 16'h0031);
    sc(16'h0030, 32'd9, 1'b1, "R6 other addr keeps");
    ll(16'h0030, 32'd9, "R1 ll");
    snoop_only(2'b10, 16'h0000, 16'h0030);
    sc(16'h0030, 32'd3, 1'b0, "R6 snoop kill port1");

    ll(16'h0040, 32'd0, "R1 ll");
    issue(2'b11, 16'h0040, 32'd2, 2'b10, 16'h0000, 16'h0040, 1'b0, 32'd0, "R7 snoop wins");
    ld(16'h0040, 32'd0, "R7 no write");
    ll(16'h0044, 32'd0, "R1 ll");
    issue(2'b11, 16'h0044, 32'd2, 2'b01, 16'h0045, 16'h0000, 1'b1, 32'd1, "R7 near miss");

    issue(2'b10, 16'h0050, '0, 2'b01, 16'h0050, 16'h0000, 1'b1, 32'd0, "R8 ll with snoop");
    sc(16'h0050, 32'd4, 1'b0, "R8 ll killed");
    issue(2'b10, 16'h0050, '0, 2'b01, 16'h0051, 16'h0000, 1'b1, 32'd0, "R8 ll snoop near");
    sc(16'h0050, 32'd4, 1'b1, "R8 ll kept");

    ll(16'h0060, 32'd0, "R8 first ll");
    ll(16'h0070, 32'd0, "R8 second ll");
    sc(16'h0060, 32'd1, 1'b0, "R8 old link replaced");
    ll(16'h0060, 32'd0, "R8 first ll");
    ll(16'h0070, 32'd0, "R8 second ll");
    sc(16'h0070, 32'd1, 1'b1, "R8 new link used");

    ll(16'h0080, 32'd0, "R1 ll");
    st(16'h0080, 32'd3, "R9 own store");
    ld(16'h0080, 32'd3, "R9 own load");
    sc(16'h0080, 32'd4, 1'b1, "R9 link kept");
    ld(16'h0080, 32'd4, "R9 sc written");

    @(negedge clk); @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11 missing responses act=%0d exp=0", exp_q.size());
    end
    finish_run();
  end
endmodule